// File: doc/BRIEF.md
# EPROM Programming Sequencer

This controller burns a run of bytes into a 2048 x 8 ultraviolet-erasable read-only memory through its parallel pins. A start command supplies a first address, a byte count and a choice of read-back verify. The bytes then arrive one by one on a valid/ready stream. The sequencer produces only digital enables for the two supply rails. It raises the logic supply first and the high programming supply second, and waits a settle interval after each change.

For each location the sequencer fetches a byte and drives the address and data. After a settle interval it gives the program pin one active-high pulse of fixed length. When verify is on, it drops the programming supply to its read level and reads the location back. The expected value is the erased pattern ANDed with the written byte. At the end, or on any fault, the supplies are removed in the opposite order to power-up. A guard counter on the program pin bounds every pulse, so the pin can never rest at a static high level.

All delays are cycle counts given as parameters. The defaults assume a 125 MHz clock, a 50 ms pulse and a 55 ms ceiling.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done, error, supply enables, program pin, data drive and stream ready are all 0, output enable (active low) is 1.
- R2: The programming supply enable is only 1 while the logic supply enable is 1. It rises at least SETTLE_CYC cycles after the logic supply enable rises. It falls at least SETTLE_CYC cycles before the logic supply enable falls.
- R3: While the program pin is 1, output enable is 1, the programming supply enable is 1 and the data bus is driven. Address and data hold unchanged for at least SETTLE_CYC cycles before the pulse and throughout it.
- R4: Every programmed location gets exactly one active-high program pulse of exactly PULSE_CYC cycles.
- R5: The program pin is never 1 for more than MAX_PULSE_CYC consecutive cycles. If the pulse state outlasts that limit, the pin is forced to 0, error is set and the supplies are shut down in order.
- R6: Locations are written from the start address upward, wrapping modulo 2048. One stream byte is taken per location, and its bits that are 0 become 0 in that location.
- R7: With verify on, each location is read back with the programming supply at read level, program pin 0 and output enable 0. A read value other than the written byte sets error and ends the run with no further bytes taken.
- R8: busy is 1 from the cycle after an accepted start until shutdown ends. done goes to 1 at the end and stays there until the next accepted start. A start while busy has no effect.
- R9: A start with a length of 0 sets done at once without enabling any supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| start_addr_i | input | ADDR_W | First location to write |
| length_i | input | ADDR_W+1 | Number of locations (0 to 2048) |
| verify_en_i | input | 1 | Enable read-back after each pulse |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | DATA_W | Stream byte |
| in_ready_o | output | 1 | Sequencer takes a byte this cycle |
| mem_addr_o | output | ADDR_W | Memory address pins |
| mem_data_o | output | DATA_W | Data driven toward the memory |
| mem_data_oe_o | output | 1 | Drive enable for the data pins |
| mem_data_i | input | DATA_W | Data read from the memory |
| ce_pgm_o | output | 1 | Chip-enable / program pin |
| oe_n_o | output | 1 | Output enable, active low |
| vcc_en_o | output | 1 | Logic supply enable |
| vpp_hi_o | output | 1 | Programming supply at high level |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished |
| error_o | output | 1 | Last run ended on a verify mismatch or pulse overrun |

## Verification
The main instance uses SETTLE_CYC=3, PULSE_CYC=20 and MAX_PULSE_CYC=25. At these values a whole run lasts a few hundred cycles, so the bench can count every pulse width and settle gap exactly. It can also cover address wrap at the top of the array and a verify failure on a location preset to a partly programmed value. A second instance uses PULSE_CYC=40 against the same 25-cycle ceiling. This forces the guard to trip, which no correct parameter set can otherwise do.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VCC_UP,
    ST_VPP_UP,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RD_DROP,
    ST_RD_SAMPLE,
    ST_VPP_DN,
    ST_VCC_DN
  } seq_state_e;

endpackage

// File: rtl/eprom_step_timer.sv
module eprom_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/eprom_pulse_guard.sv
module eprom_pulse_guard #(
  parameter int MAX_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pin_o,
  output logic trip_o
);

  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (req_i) cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pin_o  = req_i && (cnt_q < LIMIT);
  assign trip_o = req_i && (cnt_q == LIMIT);

  // Independent run-length count of the pin itself.
  logic [CW:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (pin_o) hi_run_q <= (hi_run_q > (CW+1)'(MAX_CYC)) ? hi_run_q : hi_run_q + 1'b1;
    else            hi_run_q <= '0;
  end

  a_r5_pin_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= (CW+1)'(MAX_CYC));

  a_r5_trip_releases_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && hi_run_q == (CW+1)'(MAX_CYC)) |-> !pin_o);

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYC    = 16,
  parameter int PULSE_CYC     = 6_250_000,
  parameter int MAX_PULSE_CYC = 6_875_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   length_i,
  input  logic              verify_en_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              ce_pgm_o,
  output logic              oe_n_o,
  output logic              vcc_en_o,
  output logic              vpp_hi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int TMR_MAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] T_PULSE  = TMR_W'(PULSE_CYC - 1);
  localparam logic [DATA_W-1:0] ERASED  = '1;

  // Reset: asynchronous assert, synchronous release.
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_s1_q} <= 2'b00;
    else        {rst_sync_n, rst_s1_q} <= {rst_s1_q, 1'b1};
  end

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W:0]   rem_q, rem_d;
  logic              verify_q, verify_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic pulse_req, trip;
  logic last_loc, rd_ok;

  eprom_step_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .expired_o(tmr_exp)
  );

  eprom_pulse_guard #(.MAX_CYC(MAX_PULSE_CYC)) u_guard (
    .clk(clk), .rst_n(rst_sync_n), .req_i(pulse_req),
    .pin_o(ce_pgm_o), .trip_o(trip)
  );

  assign last_loc = (rem_q == (ADDR_W+1)'(1));
  assign rd_ok    = (mem_data_i == (ERASED & data_q));

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    data_d   = data_q;
    rem_d    = rem_q;
    verify_d = verify_q;
    done_d   = done_q;
    err_d    = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        done_d = 1'b0;
        err_d  = 1'b0;
        if (length_i == '0) begin
          done_d = 1'b1;
        end else begin
          addr_d   = start_addr_i;
          rem_d    = length_i;
          verify_d = verify_en_i;
          state_d  = ST_VCC_UP;
        end
      end
      ST_VCC_UP: if (tmr_exp) state_d = ST_VPP_UP;
      ST_VPP_UP: if (tmr_exp) state_d = ST_FETCH;
      ST_FETCH: if (in_valid_i) begin
        data_d  = in_data_i;
        state_d = ST_SETUP;
      end
      ST_SETUP: if (tmr_exp) state_d = ST_PULSE;
      ST_PULSE: begin
        if (trip) begin
          err_d   = 1'b1;
          state_d = ST_VPP_DN;
        end else if (tmr_exp) begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: if (tmr_exp) begin
        if (verify_q) begin
          state_d = ST_RD_DROP;
        end else if (last_loc) begin
          state_d = ST_VPP_DN;
        end else begin
          addr_d  = addr_q + 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_RD_DROP: if (tmr_exp) state_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE: if (tmr_exp) begin
        if (!rd_ok) begin
          err_d   = 1'b1;
          state_d = ST_VPP_DN;
        end else if (last_loc) begin
          state_d = ST_VPP_DN;
        end else begin
          addr_d  = addr_q + 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = ST_VPP_UP;
        end
      end
      ST_VPP_DN: if (tmr_exp) state_d = ST_VCC_DN;
      ST_VCC_DN: if (tmr_exp) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    tmr_load = (state_d != state_q);
    tmr_val  = (state_d == ST_PULSE) ? T_PULSE : T_SETTLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      rem_q    <= '0;
      verify_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      rem_q    <= rem_d;
      verify_q <= verify_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign pulse_req     = (state_q == ST_PULSE);
  assign vcc_en_o      = (state_q != ST_IDLE) && (state_q != ST_VCC_DN);
  assign vpp_hi_o      = (state_q inside {ST_VPP_UP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD});
  assign mem_data_oe_o = (state_q inside {ST_SETUP, ST_PULSE, ST_HOLD});
  assign oe_n_o        = (state_q != ST_RD_SAMPLE);
  assign in_ready_o    = (state_q == ST_FETCH);
  assign mem_addr_o    = addr_q;
  assign mem_data_o    = data_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign error_o       = err_q;

  a_r2_vpp_needs_vcc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vpp_hi_o |-> vcc_en_o);

  a_r2_vcc_drops_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(vcc_en_o) |-> !$past(vpp_hi_o));

  a_r3_pulse_conditions: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_pgm_o |-> (oe_n_o && vpp_hi_o && mem_data_oe_o));

  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_pgm_o |-> ($stable(mem_addr_o) && $stable(mem_data_o)));

  a_r6_ready_only_programming: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready_o |-> (vpp_hi_o && !ce_pgm_o && !mem_data_oe_o));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> (!vcc_en_o && !in_ready_o && !ce_pgm_o));

endmodule

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;

  localparam int SETTLE = 3;
  localparam int PULSE  = 20;
  localparam int MAXP   = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic        start;
  logic [10:0] start_addr;
  logic [11:0] length;
  logic        verify_en;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic [10:0] addr;
  logic [7:0]  dout;
  logic        doe;
  logic [7:0]  din;
  logic        ce, oe_n, vcc, vpp, busy, done, err;

  eprom_prog_seq #(.SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE), .MAX_PULSE_CYC(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .length_i(length), .verify_en_i(verify_en), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .mem_addr_o(addr),
    .mem_data_o(dout), .mem_data_oe_o(doe), .mem_data_i(din),
    .ce_pgm_o(ce), .oe_n_o(oe_n), .vcc_en_o(vcc), .vpp_hi_o(vpp),
    .busy_o(busy), .done_o(done), .error_o(err)
  );

  // Overrun instance: programmed pulse longer than the ceiling.
  logic        wd_start;
  logic        wd_ready, wd_doe, wd_ce, wd_oe_n, wd_vcc, wd_vpp, wd_busy, wd_done, wd_err;
  logic [10:0] wd_addr;
  logic [7:0]  wd_dout;
  eprom_prog_seq #(.SETTLE_CYC(SETTLE), .PULSE_CYC(40), .MAX_PULSE_CYC(MAXP)) u_dut_wd (
    .clk(clk), .rst_n(rst_n), .start_i(wd_start), .start_addr_i(11'd7),
    .length_i(12'd1), .verify_en_i(1'b0), .in_valid_i(1'b1),
    .in_data_i(8'h00), .in_ready_o(wd_ready), .mem_addr_o(wd_addr),
    .mem_data_o(wd_dout), .mem_data_oe_o(wd_doe), .mem_data_i(8'hFF),
    .ce_pgm_o(wd_ce), .oe_n_o(wd_oe_n), .vcc_en_o(wd_vcc), .vpp_hi_o(wd_vpp),
    .busy_o(wd_busy), .done_o(wd_done), .error_o(wd_err)
  );

  // Memory model
  logic [7:0] rom [0:2047];
  assign din = (vcc && !ce && !oe_n) ? rom[addr] : 8'hFF;

  // Byte source
  logic [7:0] src [0:15];
  int src_len = 0;
  int src_idx = 0;
  bit hs_pend = 1'b0;
  always @(negedge clk) begin
    if (hs_pend) src_idx++;
    in_valid = (src_idx < src_len);
    in_data  = in_valid ? src[src_idx] : 8'h00;
    hs_pend  = in_valid && in_ready;
  end

  // Monitors
  int cyc = 0, run = 0, pulses = 0, max_run = 0, width_bad = 0;
  int stab = 0, setup_bad = 0, order_bad = 0, vcc_rises = 0, busy_cyc = 0;
  int t_vcc_up = 0, t_vpp_dn = 0;
  int wd_run = 0, wd_max = 0;
  logic [10:0] p_addr = '0;
  logic [7:0]  p_data = '0;
  logic p_doe = 1'b0, p_ce = 1'b0, p_vcc = 1'b0, p_vpp = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (ce) run++;
    else begin
      if (run > 0) begin pulses++; if (run != PULSE) width_bad++; end
      run = 0;
    end
    if (run > max_run) max_run = run;
    if (ce && vpp && oe_n && doe) rom[addr] = rom[addr] & dout;
    if (addr != p_addr || dout != p_data || doe != p_doe) begin
      if (ce && p_ce) setup_bad++;
      stab = 0;
    end else stab++;
    if (ce && !p_ce && stab < SETTLE) setup_bad++;
    if (ce && (!oe_n || !vpp || !doe)) setup_bad++;
    if (vcc && !p_vcc) begin vcc_rises++; t_vcc_up = cyc; end
    if (vpp && !p_vpp && (cyc - t_vcc_up < SETTLE)) order_bad++;
    if (!vpp && p_vpp) t_vpp_dn = cyc;
    if (!vcc && p_vcc && ((cyc - t_vpp_dn < SETTLE) || vpp)) order_bad++;
    if (vpp && !vcc) order_bad++;
    if (busy) busy_cyc++;
    p_addr = addr; p_data = dout; p_doe = doe; p_ce = ce; p_vcc = vcc; p_vpp = vpp;
    if (wd_ce) wd_run++; else wd_run = 0;
    if (wd_run > wd_max) wd_max = wd_run;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #2;
    pulses = 0; max_run = 0; width_bad = 0; setup_bad = 0;
    order_bad = 0; vcc_rises = 0; busy_cyc = 0;
  endtask

  task automatic erase_all();
    for (int i = 0; i < 2048; i++) rom[i] = 8'hFF;
  endtask

  task automatic launch(input int a, input int len, input bit ver);
    @(posedge clk); #2;
    src_idx = 0;
    start_addr = 11'(a); length = 12'(len); verify_en = ver; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy && done, req, int'(done), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !err, "R1 status", int'({busy, done, err}), 0);
    check(!vcc && !vpp && !ce && !doe, "R1 pins", int'({vcc, vpp, ce, doe}), 0);
    check(oe_n && !in_ready, "R1 oe_n/ready", int'({oe_n, in_ready}), 2);
  endtask

  task automatic t_basic();
    erase_all(); clear_mon();
    src[0] = 8'h12; src[1] = 8'hA5; src[2] = 8'h00; src_len = 3;
    launch(5, 3, 1'b0);
    wait_done("R8 done after basic run");
    check(rom[5] == 8'h12, "R6 byte at 5", rom[5], 8'h12);
    check(rom[6] == 8'hA5, "R6 byte at 6", rom[6], 8'hA5);
    check(rom[7] == 8'h00, "R6 byte at 7", rom[7], 8'h00);
    check(rom[8] == 8'hFF && rom[4] == 8'hFF, "R6 neighbours untouched", rom[8], 8'hFF);
    check(pulses == 3, "R4 pulse count", pulses, 3);
    check(width_bad == 0, "R4 pulse width", width_bad, 0);
    check(order_bad == 0, "R2 supply order", order_bad, 0);
    check(setup_bad == 0, "R3 setup and stability", setup_bad, 0);
    check(!err, "R8 no error", int'(err), 0);
    check(src_idx == 3, "R6 bytes consumed", src_idx, 3);
  endtask

  task automatic t_wrap_verify();
    erase_all(); clear_mon();
    src[0] = 8'h3C; src[1] = 8'h81; src[2] = 8'hFE; src[3] = 8'h00; src_len = 4;
    launch(2046, 4, 1'b1);
    wait_done("R8 done after wrap run");
    check(rom[2046] == 8'h3C, "R6 wrap 2046", rom[2046], 8'h3C);
    check(rom[2047] == 8'h81, "R6 wrap 2047", rom[2047], 8'h81);
    check(rom[0] == 8'hFE, "R6 wrap 0", rom[0], 8'hFE);
    check(rom[1] == 8'h00, "R6 wrap 1", rom[1], 8'h00);
    check(!err, "R7 verify passes", int'(err), 0);
    check(pulses == 4 && width_bad == 0, "R4 wrap pulses", pulses, 4);
    check(order_bad == 0 && setup_bad == 0, "R2 R3 with verify", order_bad + setup_bad, 0);
  endtask

  task automatic t_start_busy();
    erase_all(); clear_mon();
    src[0] = 8'h11; src[1] = 8'h22; src_len = 2;
    launch(100, 2, 1'b0);
    repeat (12) @(posedge clk);
    #2; start_addr = 11'd300; length = 12'd5; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    wait_done("R8 done despite extra start");
    check(rom[300] == 8'hFF, "R8 start while busy ignored", rom[300], 8'hFF);
    check(pulses == 2, "R8 only original run", pulses, 2);
    check(rom[101] == 8'h22, "R6 second byte", rom[101], 8'h22);
    repeat (5) @(negedge clk);
    check(done && !busy, "R8 done held", int'(done), 1);
  endtask

  task automatic t_verify_fail();
    erase_all(); clear_mon();
    rom[200] = 8'h0F;
    src[0] = 8'h55; src[1] = 8'h55; src[2] = 8'h55; src_len = 3;
    launch(199, 3, 1'b1);
    wait_done("R7 run ends on mismatch");
    check(err, "R7 error on mismatch", int'(err), 1);
    check(pulses == 2, "R7 stops after bad location", pulses, 2);
    check(rom[201] == 8'hFF, "R7 later location untouched", rom[201], 8'hFF);
    check(src_idx == 2, "R7 no further bytes", src_idx, 2);
    check(!vcc && !vpp && order_bad == 0, "R2 shutdown after abort", order_bad, 0);
  endtask

  task automatic t_zero_len();
    clear_mon();
    src_len = 0;
    launch(10, 0, 1'b0);
    @(negedge clk);
    check(done && !err, "R9 done at once", int'(done), 1);
    check(vcc_rises == 0 && busy_cyc == 0, "R9 no supply", vcc_rises + busy_cyc, 0);
  endtask

  task automatic t_overrun();
    @(posedge clk); #2; wd_start = 1'b1;
    @(posedge clk); #2; wd_start = 1'b0;
    for (int n = 0; n < 2000 && !wd_done; n++) @(negedge clk);
    check(wd_max == MAXP, "R5 pulse capped", wd_max, MAXP);
    check(wd_err && wd_done, "R5 error on overrun", int'(wd_err), 1);
    check(!wd_vcc && !wd_vpp && !wd_ce, "R5 supplies off", int'({wd_vcc, wd_vpp}), 0);
    check(max_run <= MAXP, "R5 main instance bounded", max_run, MAXP);
  endtask

  initial begin
    start = 1'b0; wd_start = 1'b0; start_addr = '0; length = '0; verify_en = 1'b0;
    erase_all();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_basic();
    t_wrap_verify();
    t_start_busy();
    t_verify_fail();
    t_zero_len();
    t_overrun();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule